// File: doc/BRIEF.md
# Prefetch Queue Mirror and Instruction Framer

This block rebuilds a processor's instruction prefetch queue from outside the processor. A bus cycle tracker sends it every byte fetched during a code-read bus cycle. The two queue-status lines tell it when the processor takes a byte out of its own queue. A 4-deep FIFO mirrors the internal queue. Each byte the processor consumes leaves that FIFO and goes into an instruction framer. The framer finds where each instruction starts and ends.

Prefix bytes stay with the opcode that follows them, so one framed instruction covers its prefixes, its opcode and its trailing bytes. When the next instruction begins, the block sends out one report for the instruction that just ended. The report holds the opcode byte, the byte after the opcode (usually a modrm byte), the total byte count and the cycle count at which the instruction started.

A capture can begin in the middle of a program, so the mirror may overflow or underflow. It keeps running in that case and records each event in a sticky flag. The next flush or empty-queue indication clears the mirror and both flags.

Top module: `pfq_mirror`

## Requirements
- R1: On each clock where `fetchValid` is 1, the byte on `fetchByte` is pushed into a FIFO of DEPTH (default 4) entries, and `queueLevel` gives the number of stored bytes after each clock.
- R2: `qStat` encodes 00 = idle (the queue and framer are unchanged), 01 = first byte of an instruction, 11 = subsequent byte. Codes 01 and 11 each pop the oldest stored byte and append it to the instruction buffer.
- R3: A push when the queue holds DEPTH bytes and no pop happens on that clock is dropped, and the sticky `overflowFlag` is set. A push and a pop on the same clock are both applied, with the pop taking the oldest entry, so a full queue stays full without overflow.
- R4: A pop from an empty queue delivers byte 0x00 to the framer and sets the sticky `underflowFlag`. A push on that same clock is still stored.
- R5: `qStat` = 10 (empty queue) or `flushReq` = 1 empties the queue and clears both sticky flags on that clock. A push on the same clock is discarded.
- R6: A first-byte pop while an instruction is in progress closes it. On the next clock, `instrValid` is 1 for one cycle with `instrOpcode`, `instrSecond` (0x00 if no byte followed the opcode), `instrLen` and `instrStart`. The buffer then restarts with the new byte. `instrLen` saturates at 15.
- R7: The prefix bytes are 0x26, 0x2E, 0x36, 0x3E, 0xF0, 0xF2 and 0xF3. A prefix popped as a first byte makes the framer wait for an opcode without closing anything. The following non-prefix first byte is reported as `instrOpcode`, and `instrLen` counts the prefixes too.
- R8: The cycle counter is 0 at the first rising edge after reset and increases by 1 at each edge. A first-byte pop records the counter value of its own edge as the start time, unless the framer is waiting for an opcode after a prefix. So a prefixed instruction starts at its first prefix.
- R9: After reset, the queue is empty, both flags are 0, `instrValid` is 0, and all report outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | A code byte was fetched on this clock |
| fetchByte | input | 8 | Fetched code byte |
| flushReq | input | 1 | Empty the mirrored queue |
| qStat | input | 2 | Queue-status code: 00 idle, 01 first, 10 empty, 11 subsequent |
| instrValid | output | 1 | One-cycle pulse: an instruction report is present |
| instrOpcode | output | 8 | Opcode byte of the reported instruction |
| instrSecond | output | 8 | Byte after the opcode, 0x00 if none |
| instrLen | output | LEN_W | Byte count including prefixes, saturating |
| instrStart | output | TS_W | Cycle count at instruction start |
| queueLevel | output | $clog2(DEPTH)+1 | Number of bytes in the mirrored queue |
| overflowFlag | output | 1 | Sticky: a fetched byte was dropped |
| underflowFlag | output | 1 | Sticky: a pop found the queue empty |

## Verification
The bound checker tests the queue level on every cycle. The level never exceeds DEPTH, it grows by one on a lone push and stays put on idle cycles. A full queue keeps its level and raises the overflow flag on a lone push. Both sticky flags stay set until they are cleared, and a flush or empty code always leaves the queue and flags cleared. A report pulse may only follow a first-byte code and always has a non-zero length. Only the bench scenarios can show the byte order through the FIFO, how prefixes are grouped, the start timestamps and the length saturation, because each of these depends on a whole sequence of fetches and pops.

// File: rtl/pfq_pkg.sv
package pfq_pkg;

  // queue-status codes as driven on qStat
  typedef enum logic [1:0] {
    QS_IDLE  = 2'b00,
    QS_FIRST = 2'b01,
    QS_EMPTY = 2'b10,
    QS_NEXT  = 2'b11
  } qop_e;

  // framer state
  typedef enum logic [1:0] {
    FR_IDLE   = 2'b00,
    FR_WAITOP = 2'b01,
    FR_INSTR  = 2'b10
  } frame_e;

  // strobes from control to datapath
  typedef struct packed {
    logic push;        // fetch byte offered
    logic pop;         // take oldest byte
    logic clear;       // empty queue, clear sticky flags
    logic bufRestart;  // length restarts at this pop
    logic bufAppend;   // popped byte joins the buffer
    logic capOpcode;   // popped byte is the opcode
    logic capSecond;   // popped byte follows the opcode
    logic setStart;    // record start timestamp
    logic emit;        // publish the buffered instruction
  } ctl_t;

  function automatic logic isPrefix(input logic [7:0] b);
    case (b)
      8'h26, 8'h2E, 8'h36, 8'h3E, 8'hF0, 8'hF2, 8'hF3: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/pfq_ctrl.sv
module pfq_ctrl
  import pfq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fetchValid,
  input  logic       flushReq,
  input  logic [1:0] qStat,
  input  logic [7:0] popByte,
  output ctl_t       ctl
);

  frame_e state, nextState;
  logic   haveSecond, nextHave;

  always_comb begin
    ctl       = '0;
    nextState = state;
    nextHave  = haveSecond;
    ctl.push  = fetchValid;
    ctl.clear = flushReq || (qStat == QS_EMPTY);
    case (qStat)
      QS_FIRST: begin
        ctl.pop        = 1'b1;
        ctl.bufAppend  = 1'b1;
        ctl.emit       = (state == FR_INSTR);
        ctl.bufRestart = (state != FR_WAITOP);
        ctl.setStart   = (state != FR_WAITOP);
        if (isPrefix(popByte)) begin
          nextState = FR_WAITOP;
        end else begin
          nextState     = FR_INSTR;
          ctl.capOpcode = 1'b1;
          nextHave      = 1'b0;
        end
      end
      QS_NEXT: begin
        ctl.pop       = 1'b1;
        ctl.bufAppend = 1'b1;
        if (state == FR_INSTR && !haveSecond) begin
          ctl.capSecond = 1'b1;
          nextHave      = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= FR_IDLE;
      haveSecond <= 1'b0;
    end else begin
      state      <= nextState;
      haveSecond <= nextHave;
    end
  end

endmodule

// File: rtl/pfq_datapath.sv
module pfq_datapath
  import pfq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = 4,
  parameter int TS_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctl_t                     ctl,
  input  logic [7:0]               fetchByte,
  output logic [7:0]               popByte,
  output logic [$clog2(DEPTH):0]   queueLevel,
  output logic                     overflowFlag,
  output logic                     underflowFlag,
  output logic                     instrValid,
  output logic [7:0]               instrOpcode,
  output logic [7:0]               instrSecond,
  output logic [LEN_W-1:0]         instrLen,
  output logic [TS_W-1:0]          instrStart
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int LVL_W = PTR_W + 1;
  localparam logic [LVL_W-1:0] FULL   = LVL_W'(DEPTH);
  localparam logic [LEN_W-1:0] MAXLEN = '1;

  logic [7:0]       mem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [LVL_W-1:0] count;
  logic             isEmpty, isFull, pushOk, popEff;

  logic [7:0]       opReg, secReg;
  logic [LEN_W-1:0] lenReg;
  logic [TS_W-1:0]  startReg, cycCnt;

  assign isEmpty    = (count == '0);
  assign isFull     = (count == FULL);
  assign popEff     = ctl.pop && !isEmpty;
  assign pushOk     = ctl.push && !ctl.clear && (!isFull || ctl.pop);
  assign popByte    = isEmpty ? 8'h00 : mem[rdPtr];
  assign queueLevel = count;

  // queue storage
  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= fetchByte;
  end

  // queue pointers, level and sticky flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr         <= '0;
      rdPtr         <= '0;
      count         <= '0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else if (ctl.clear) begin
      wrPtr         <= '0;
      rdPtr         <= '0;
      count         <= '0;
      overflowFlag  <= 1'b0;
      underflowFlag <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= wrPtr + 1'b1;
      if (popEff) rdPtr <= rdPtr + 1'b1;
      count <= count + LVL_W'(pushOk) - LVL_W'(popEff);
      if (ctl.push && isFull && !ctl.pop) overflowFlag <= 1'b1;
      if (ctl.pop && isEmpty) underflowFlag <= 1'b1;
    end
  end

  // instruction buffer and timestamp
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycCnt   <= '0;
      lenReg   <= '0;
      opReg    <= '0;
      secReg   <= '0;
      startReg <= '0;
    end else begin
      cycCnt <= cycCnt + 1'b1;
      if (ctl.bufAppend) begin
        if (ctl.bufRestart)         lenReg <= LEN_W'(1);
        else if (lenReg != MAXLEN)  lenReg <= lenReg + 1'b1;
      end
      if (ctl.capOpcode) begin
        opReg  <= popByte;
        secReg <= 8'h00;
      end
      if (ctl.capSecond) secReg   <= popByte;
      if (ctl.setStart)  startReg <= cycCnt;
    end
  end

  // report register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      instrValid  <= 1'b0;
      instrOpcode <= '0;
      instrSecond <= '0;
      instrLen    <= '0;
      instrStart  <= '0;
    end else begin
      instrValid <= ctl.emit;
      if (ctl.emit) begin
        instrOpcode <= opReg;
        instrSecond <= secReg;
        instrLen    <= lenReg;
        instrStart  <= startReg;
      end
    end
  end

endmodule

// File: rtl/pfq_mirror.sv
module pfq_mirror
  import pfq_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = 4,
  parameter int TS_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   fetchValid,
  input  logic [7:0]             fetchByte,
  input  logic                   flushReq,
  input  logic [1:0]             qStat,
  output logic                   instrValid,
  output logic [7:0]             instrOpcode,
  output logic [7:0]             instrSecond,
  output logic [LEN_W-1:0]       instrLen,
  output logic [TS_W-1:0]        instrStart,
  output logic [$clog2(DEPTH):0] queueLevel,
  output logic                   overflowFlag,
  output logic                   underflowFlag
);

  ctl_t       ctl;
  logic [7:0] popByte;

  pfq_ctrl ctrl_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fetchValid (fetchValid),
    .flushReq   (flushReq),
    .qStat      (qStat),
    .popByte    (popByte),
    .ctl        (ctl)
  );

  pfq_datapath #(.DEPTH(DEPTH), .LEN_W(LEN_W), .TS_W(TS_W)) dp_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .ctl           (ctl),
    .fetchByte     (fetchByte),
    .popByte       (popByte),
    .queueLevel    (queueLevel),
    .overflowFlag  (overflowFlag),
    .underflowFlag (underflowFlag),
    .instrValid    (instrValid),
    .instrOpcode   (instrOpcode),
    .instrSecond   (instrSecond),
    .instrLen      (instrLen),
    .instrStart    (instrStart)
  );

endmodule

// File: rtl/pfq_mirror_chk.sv
module pfq_mirror_chk #(
  parameter int DEPTH = 4,
  parameter int LEN_W = 4,
  parameter int TS_W  = 16
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   fetchValid,
  input logic [7:0]             fetchByte,
  input logic                   flushReq,
  input logic [1:0]             qStat,
  input logic                   instrValid,
  input logic [7:0]             instrOpcode,
  input logic [7:0]             instrSecond,
  input logic [LEN_W-1:0]       instrLen,
  input logic [TS_W-1:0]        instrStart,
  input logic [$clog2(DEPTH):0] queueLevel,
  input logic                   overflowFlag,
  input logic                   underflowFlag
);

  localparam int LVL_W = $clog2(DEPTH) + 1;
  localparam logic [LVL_W-1:0] FULL = LVL_W'(DEPTH);

  p_level_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    queueLevel <= FULL);

  p_push_grows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchValid && qStat == 2'b00 && !flushReq && queueLevel < FULL)
    |=> queueLevel == $past(queueLevel) + LVL_W'(1));

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetchValid && qStat == 2'b00 && !flushReq) |=> $stable(queueLevel));

  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fetchValid && qStat == 2'b00 && !flushReq && queueLevel == FULL)
    |=> (overflowFlag && queueLevel == FULL));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (overflowFlag && !flushReq && qStat != 2'b10) |=> overflowFlag);

  p_unf_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (qStat[0] && queueLevel == '0 && !flushReq) |=> underflowFlag);

  p_unf_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (underflowFlag && !flushReq && qStat != 2'b10) |=> underflowFlag);

  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flushReq || qStat == 2'b10)
    |=> (queueLevel == '0 && !overflowFlag && !underflowFlag));

  p_emit_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
    instrValid |-> $past(qStat) == 2'b01);

  p_emit_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    instrValid |-> instrLen != '0);

endmodule

bind pfq_mirror pfq_mirror_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .TS_W(TS_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetchValid    (fetchValid),
  .fetchByte     (fetchByte),
  .flushReq      (flushReq),
  .qStat         (qStat),
  .instrValid    (instrValid),
  .instrOpcode   (instrOpcode),
  .instrSecond   (instrSecond),
  .instrLen      (instrLen),
  .instrStart    (instrStart),
  .queueLevel    (queueLevel),
  .overflowFlag  (overflowFlag),
  .underflowFlag (underflowFlag)
);

// File: tb/pfq_mirror_tb.sv
module pfq_mirror_tb_top;

  localparam int DEPTH = 4;
  localparam int LEN_W = 4;
  localparam int TS_W  = 16;
  localparam int NVEC  = 17;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetchValid = 1'b0;
  logic [7:0]  fetchByte = 8'h00;
  logic        flushReq = 1'b0;
  logic [1:0]  qStat = 2'b00;
  logic        instrValid;
  logic [7:0]  instrOpcode, instrSecond;
  logic [LEN_W-1:0] instrLen;
  logic [TS_W-1:0]  instrStart;
  logic [2:0]  queueLevel;
  logic        overflowFlag, underflowFlag;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;
  logic [TS_W-1:0] benchCyc;

  always #10 clk = ~clk;  // 50 MHz

  pfq_mirror #(.DEPTH(DEPTH), .LEN_W(LEN_W), .TS_W(TS_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .fetchValid(fetchValid), .fetchByte(fetchByte),
    .flushReq(flushReq), .qStat(qStat), .instrValid(instrValid),
    .instrOpcode(instrOpcode), .instrSecond(instrSecond), .instrLen(instrLen),
    .instrStart(instrStart), .queueLevel(queueLevel),
    .overflowFlag(overflowFlag), .underflowFlag(underflowFlag)
  );

  // bench's own clock count since reset release (R8)
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) benchCyc <= '0;
    else        benchCyc <= benchCyc + 1'b1;
  end

  // vector: fv | fb | fl | qs || expValid | expOp | expSec | expLen | expLvl
  localparam logic [35:0] VEC [NVEC] = '{
    {1'b1, 8'h90, 1'b0, 2'b00, 1'b0, 8'h00, 8'h00, 4'd0, 3'd1},
    {1'b1, 8'h3E, 1'b0, 2'b00, 1'b0, 8'h00, 8'h00, 4'd0, 3'd2},
    {1'b1, 8'h8B, 1'b0, 2'b00, 1'b0, 8'h00, 8'h00, 4'd0, 3'd3},
    {1'b1, 8'h46, 1'b0, 2'b00, 1'b0, 8'h00, 8'h00, 4'd0, 3'd4},
    {1'b1, 8'h55, 1'b0, 2'b00, 1'b0, 8'h00, 8'h00, 4'd0, 3'd4},
    {1'b0, 8'h00, 1'b0, 2'b01, 1'b0, 8'h00, 8'h00, 4'd0, 3'd3},
    {1'b0, 8'h00, 1'b0, 2'b01, 1'b1, 8'h90, 8'h00, 4'd1, 3'd2},
    {1'b1, 8'hC3, 1'b0, 2'b01, 1'b0, 8'h00, 8'h00, 4'd0, 3'd2},
    {1'b0, 8'h00, 1'b0, 2'b11, 1'b0, 8'h00, 8'h00, 4'd0, 3'd1},
    {1'b0, 8'h00, 1'b0, 2'b01, 1'b1, 8'h8B, 8'h46, 4'd3, 3'd0},
    {1'b0, 8'h00, 1'b0, 2'b01, 1'b1, 8'hC3, 8'h00, 4'd1, 3'd0},
    {1'b1, 8'hF3, 1'b0, 2'b10, 1'b0, 8'h00, 8'h00, 4'd0, 3'd0},
    {1'b1, 8'hF3, 1'b0, 2'b00, 1'b0, 8'h00, 8'h00, 4'd0, 3'd1},
    {1'b1, 8'hA4, 1'b0, 2'b01, 1'b1, 8'h00, 8'h00, 4'd1, 3'd1},
    {1'b0, 8'h00, 1'b0, 2'b01, 1'b0, 8'h00, 8'h00, 4'd0, 3'd0},
    {1'b1, 8'h12, 1'b0, 2'b11, 1'b0, 8'h00, 8'h00, 4'd0, 3'd1},
    {1'b0, 8'h00, 1'b0, 2'b01, 1'b1, 8'hA4, 8'h00, 4'd3, 3'd0}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // drive for one clock, return at the following negedge with results visible
  task automatic apply(input logic fv, input logic [7:0] fb, input logic fl, input logic [1:0] qs);
    fetchValid = fv; fetchByte = fb; flushReq = fl; qStat = qs;
    @(negedge clk);
    fetchValid = 1'b0; fetchByte = 8'h00; flushReq = 1'b0; qStat = 2'b00;
  endtask

  task automatic doReset();
    rst_n = 1'b0;
    fetchValid = 1'b0; fetchByte = 8'h00; flushReq = 1'b0; qStat = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic finishRun();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    logic [TS_W-1:0] t0, t3;

    // R9 reset state
    doReset();
    chk("R9 instrValid", 32'(instrValid), 0);
    chk("R9 level", 32'(queueLevel), 0);
    chk("R9 flags", {30'd0, overflowFlag, underflowFlag}, 0);
    chk("R9 report", {instrOpcode, instrSecond, 4'(instrLen), 12'(instrStart)}, 0);

    // vector table: R1 R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      apply(VEC[i][35], VEC[i][34:27], VEC[i][26], VEC[i][25:24]);
      chk($sformatf("R6 vec%0d valid", i), 32'(instrValid), 32'(VEC[i][23]));
      if (VEC[i][23]) begin
        chk($sformatf("R6 vec%0d opcode", i), 32'(instrOpcode), 32'(VEC[i][22:15]));
        chk($sformatf("R6 vec%0d second", i), 32'(instrSecond), 32'(VEC[i][14:7]));
        chk($sformatf("R7 vec%0d length", i), 32'(instrLen), 32'(VEC[i][6:3]));
      end
      chk($sformatf("R1 R2 vec%0d level", i), 32'(queueLevel), 32'(VEC[i][2:0]));
    end
    chk("R4 underflow after empty pop", 32'(underflowFlag), 1);
    chk("R5 overflow cleared by empty code", 32'(overflowFlag), 0);

    // R3 overflow sticky, R5 flush clears
    doReset();
    for (int i = 0; i < 5; i++) apply(1'b1, 8'(8'h60 + i), 1'b0, 2'b00);
    chk("R3 full level", 32'(queueLevel), 4);
    chk("R3 overflow set", 32'(overflowFlag), 1);
    apply(1'b0, 8'h00, 1'b0, 2'b00);
    apply(1'b0, 8'h00, 1'b0, 2'b00);
    chk("R3 overflow sticky", 32'(overflowFlag), 1);
    chk("R2 idle keeps level", 32'(queueLevel), 4);
    apply(1'b1, 8'h77, 1'b1, 2'b00);
    chk("R5 flush level", 32'(queueLevel), 0);
    chk("R5 flush clears overflow", 32'(overflowFlag), 0);

    // R3 push+pop on a full queue, order of pops
    doReset();
    for (int i = 0; i < 4; i++) apply(1'b1, 8'(8'h10 + i), 1'b0, 2'b00);
    apply(1'b1, 8'h14, 1'b0, 2'b01);
    chk("R3 push+pop level", 32'(queueLevel), 4);
    chk("R3 push+pop no overflow", 32'(overflowFlag), 0);
    for (int i = 0; i < 4; i++) begin
      apply(1'b0, 8'h00, 1'b0, 2'b01);
      chk("R3 pop order valid", 32'(instrValid), 1);
      chk("R3 pop order opcode", 32'(instrOpcode), 32'(8'h10 + i));
    end

    // R7 R8 prefix grouping and start timestamps
    doReset();
    apply(1'b1, 8'h2E, 1'b0, 2'b00);
    apply(1'b1, 8'h26, 1'b0, 2'b00);
    apply(1'b1, 8'h90, 1'b0, 2'b00);
    apply(1'b1, 8'h40, 1'b0, 2'b00);
    t0 = benchCyc;
    apply(1'b0, 8'h00, 1'b0, 2'b01);
    chk("R7 prefix no report", 32'(instrValid), 0);
    apply(1'b0, 8'h00, 1'b0, 2'b01);
    chk("R7 second prefix no report", 32'(instrValid), 0);
    apply(1'b0, 8'h00, 1'b0, 2'b01);
    t3 = benchCyc;
    apply(1'b0, 8'h00, 1'b0, 2'b01);
    chk("R7 grouped valid", 32'(instrValid), 1);
    chk("R7 grouped opcode", 32'(instrOpcode), 32'h90);
    chk("R7 grouped length", 32'(instrLen), 3);
    chk("R8 start at first prefix", 32'(instrStart), 32'(t0));
    apply(1'b0, 8'h00, 1'b0, 2'b00);
    chk("R6 pulse is one cycle", 32'(instrValid), 0);
    apply(1'b0, 8'h00, 1'b0, 2'b01);
    chk("R8 plain opcode start", 32'(instrStart), 32'(t3));
    chk("R6 plain opcode", 32'(instrOpcode), 32'h40);
    chk("R4 empty pop flagged", 32'(underflowFlag), 1);

    // R6 length saturation, R4 zero bytes, R5 flush clears underflow
    doReset();
    apply(1'b0, 8'h00, 1'b0, 2'b01);
    for (int i = 0; i < 16; i++) apply(1'b0, 8'h00, 1'b0, 2'b11);
    apply(1'b0, 8'h00, 1'b0, 2'b01);
    chk("R6 length saturates", 32'(instrLen), 15);
    chk("R4 empty pop gives zero opcode", 32'(instrOpcode), 0);
    apply(1'b0, 8'h00, 1'b1, 2'b00);
    chk("R5 flush clears underflow", 32'(underflowFlag), 0);

    done = 1'b1;
    finishRun();
  end

endmodule